// File: doc/BRIEF.md
# Shared On-Chip Bus Resolver

This block replaces a shared internal bus that would otherwise be built from high-impedance buffers. Each of `N_DRV` sources presents a `W_DATA`-bit word together with an enable bit. The block combines them into one bus word using AND/OR gating and a final selector only. No high-impedance or unknown value can appear anywhere inside it.

When exactly one source is enabled, the bus carries that source's word. Two cases would be undefined on a real tri-state bus, and both get a fixed value here. If two or more sources drive at once, every bus bit reads low. If no source drives, every bus bit reads high. Two flags report these cases to the surrounding logic: `clash` for several drivers and `bus_idle` for no driver.

The block is purely combinational, so outputs follow inputs in the same cycle. It does not register the bus or arbitrate between sources. The number of sources must be at least 2.

Top module: `emu_tristate_bus`

## Requirements
- R1: With exactly one enable bit set in `drv_oe`, `bus_word` equals the word of that source. Source i occupies bits `[i*W_DATA +: W_DATA]` of `drv_data`.
- R2: With two or more enable bits set, every bit of `bus_word` is 0, whatever the data words are.
- R3: With no enable bit set, every bit of `bus_word` is 1, whatever the data words are.
- R4: `clash` is 1 exactly when two or more bits of `drv_oe` are 1.
- R5: `bus_idle` is 1 exactly when all bits of `drv_oe` are 0.
- R6: `clash` and `bus_idle` are never 1 together, and with one enable both are 0.
- R7: The source at index 0 and the source at index `N_DRV-1` each reach the bus unchanged when enabled alone.
- R8: For any known input values, `bus_word`, `clash` and `bus_idle` contain no X or Z bit.
- R9: The outputs are a function of the present inputs only. A new input pattern is reflected in the same cycle, with no memory of earlier patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| drv_data | input | N_DRV*W_DATA | Packed words of all sources; source i at `[i*W_DATA +: W_DATA]` |
| drv_oe | input | N_DRV | Enable bit per source; bit i belongs to source i |
| bus_word | output | W_DATA | Resolved bus value |
| clash | output | 1 | Two or more sources enabled |
| bus_idle | output | 1 | No source enabled |

## Verification
Passing a single source's word and forcing the bus low on a clash can meet in one cycle. This happens when a second enable joins an already active one. The bench provokes it by sweeping all enable patterns of a four-source configuration, in an order where one-hot patterns directly neighbour multi-bit ones. In each cycle it checks that the earlier word has vanished and that the bus is all zeros with `clash` raised. Each pattern is paired with several pseudo-random data sets, including all-ones and all-zeros words. This ensures a forced value can never be mistaken for passed data.

// File: rtl/bus_emu_pkg.sv
// Package: shared types of the bus resolver.
// Assumes: consumers compare the census state by value only.
package bus_emu_pkg;

    // Occupancy of the bus derived from the enable pattern
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SOLE  = 2'd1,
        BUS_CLASH = 2'd2
    } bus_state_e;

endpackage

// File: rtl/emu_bus_census.sv
// Module: emu_bus_census
// Classifies an enable vector as idle, single-driver or clash using a
// ripple of "seen one" and "seen two" terms; no adder is built.
// Assumes: N_DRV >= 2, enables are known values.
module emu_bus_census
    import bus_emu_pkg::*;
#(
    parameter int N_DRV = 4
) (
    input  logic [N_DRV-1:0] oe,
    output bus_state_e       state
);

    logic [N_DRV-1:0] seen_one;
    logic [N_DRV-1:0] seen_two;

    assign seen_one[0] = oe[0];
    assign seen_two[0] = 1'b0;

    // Ripple of the two occupancy terms across the sources
    for (genvar gi = 1; gi < N_DRV; gi++) begin : g_ripple
        assign seen_one[gi] = seen_one[gi-1] | oe[gi];
        assign seen_two[gi] = seen_two[gi-1] | (seen_one[gi-1] & oe[gi]);
    end

    // Encode the final ripple terms into the bus state
    always_comb begin
        if (seen_two[N_DRV-1])      state = BUS_CLASH;
        else if (seen_one[N_DRV-1]) state = BUS_SOLE;
        else                        state = BUS_IDLE;
    end

    // Cross-check the ripple against a population count
    always_comb begin
        // R4
        clash_count_chk: assert ((state == BUS_CLASH) == ($countones(oe) >= 2));
        // R5
        idle_count_chk: assert ((state == BUS_IDLE) == (oe == '0));
    end

endmodule

// File: rtl/emu_bus_gate.sv
// Module: emu_bus_gate
// AND-gates each source word with its enable and ORs the results.
// The output is meaningful only when at most one enable is set.
// Assumes: N_DRV >= 2.
module emu_bus_gate #(
    parameter int N_DRV  = 4,
    parameter int W_DATA = 8
) (
    input  logic [N_DRV*W_DATA-1:0] data,
    input  logic [N_DRV-1:0]        oe,
    output logic [W_DATA-1:0]       merged
);

    logic [W_DATA-1:0] gated [N_DRV];

    // Gate every source word with its own enable
    for (genvar gi = 0; gi < N_DRV; gi++) begin : g_gate
        assign gated[gi] = data[gi*W_DATA +: W_DATA] & {W_DATA{oe[gi]}};
    end

    // OR all gated words into one
    always_comb begin
        merged = '0;
        for (int i = 0; i < N_DRV; i++) begin
            merged = merged | gated[i];
        end
    end

    // With a lone enable, the merged word matches the addressed source
    always_comb begin
        if ($onehot(oe)) begin
            for (int i = 0; i < N_DRV; i++) begin
                if (oe[i]) begin
                    // R1
                    sole_pass_chk: assert (merged == data[i*W_DATA +: W_DATA]);
                end
            end
        end
    end

endmodule

// File: rtl/emu_tristate_bus.sv
// Module: emu_tristate_bus (top)
// Resolves N_DRV enabled sources onto one bus word without Z values:
// one driver passes, a clash gives all zeros, an idle bus gives all ones.
// Assumes: N_DRV >= 2; purely combinational, so it needs no clock or reset.
module emu_tristate_bus
    import bus_emu_pkg::*;
#(
    parameter int N_DRV  = 4,
    parameter int W_DATA = 8
) (
    input  logic [N_DRV*W_DATA-1:0] drv_data,
    input  logic [N_DRV-1:0]        drv_oe,
    output logic [W_DATA-1:0]       bus_word,
    output logic                    clash,
    output logic                    bus_idle
);

    localparam logic [W_DATA-1:0] FLOAT_VALUE = {W_DATA{1'b1}};
    localparam logic [W_DATA-1:0] CLASH_VALUE = {W_DATA{1'b0}};

    bus_state_e        state;
    logic [W_DATA-1:0] merged;

    emu_bus_census #(.N_DRV(N_DRV)) u_census (
        .oe    (drv_oe),
        .state (state)
    );

    emu_bus_gate #(.N_DRV(N_DRV), .W_DATA(W_DATA)) u_gate (
        .data   (drv_data),
        .oe     (drv_oe),
        .merged (merged)
    );

    // Pick the fixed value or the gated word from the census state
    always_comb begin
        unique case (state)
            BUS_CLASH: bus_word = CLASH_VALUE;
            BUS_IDLE:  bus_word = FLOAT_VALUE;
            default:   bus_word = merged;
        endcase
    end

    // Status flags
    assign clash    = (state == BUS_CLASH);
    assign bus_idle = (state == BUS_IDLE);

    // Output-side checks against the raw enable vector
    always_comb begin
        // R2
        clash_low_chk: assert (!($countones(drv_oe) >= 2) || (bus_word == '0));
        // R3
        idle_high_chk: assert (!(drv_oe == '0) || (&bus_word));
        // R6
        flag_excl_chk: assert (!(clash && bus_idle));
        // R8
        no_unknown_chk: assert ($isunknown({drv_data, drv_oe}) ||
                                !$isunknown({bus_word, clash, bus_idle}));
    end

endmodule

// File: tb/emu_tristate_bus_tb.sv
// Exhaustive sweep of enable patterns for a 4-source, 8-bit configuration.
module emu_tristate_bus_tb;

    localparam int N = 4;
    localparam int W = 8;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N*W-1:0] drv_data;
    logic [N-1:0]   drv_oe;
    logic [W-1:0]   bus_word;
    logic           clash;
    logic           bus_idle;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    emu_tristate_bus #(.N_DRV(N), .W_DATA(W)) u_dut (
        .drv_data (drv_data),
        .drv_oe   (drv_oe),
        .bus_word (bus_word),
        .clash    (clash),
        .bus_idle (bus_idle)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h oe=%b", req, act, exp, drv_oe);
        end
    endtask

    // Drive at a rising edge, judge at the following falling edge
    task automatic apply_and_judge(input logic [N-1:0] oe, input logic [N*W-1:0] data);
        int cnt;
        logic [W-1:0] exp_bus;
        @(posedge clk);
        drv_oe   <= oe;
        drv_data <= data;
        @(negedge clk);
        cnt = 0;
        exp_bus = '1;
        for (int i = 0; i < N; i++) begin
            if (oe[i]) begin
                cnt++;
                exp_bus = data[i*W +: W];
            end
        end
        if (cnt == 0) exp_bus = '1;
        if (cnt >= 2) exp_bus = '0;
        if (cnt == 0)      check("R3 idle bus high", bus_word, exp_bus);
        else if (cnt == 1) check("R1 sole word passes", bus_word, exp_bus);
        else               check("R2 clash bus low", bus_word, exp_bus);
        check("R4 clash flag", {{(W-1){1'b0}}, clash}, {{(W-1){1'b0}}, cnt >= 2});
        check("R5 idle flag", {{(W-1){1'b0}}, bus_idle}, {{(W-1){1'b0}}, cnt == 0});
        check("R6 flags exclusive", {{(W-1){1'b0}}, clash & bus_idle}, '0);
        check("R8 no unknown", {{(W-1){1'b0}}, $isunknown({bus_word, clash, bus_idle})}, '0);
    endtask

    function automatic logic [N*W-1:0] next_data();
        logic [N*W-1:0] d;
        for (int i = 0; i < N; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            d[i*W +: W] = seed[23:16];
        end
        return d;
    endfunction

    initial begin
        drv_oe   = '0;
        drv_data = '0;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // Initial state: nothing enabled -> floating value, idle flag
        check("R3 initial idle high", bus_word, '1);
        check("R5 initial idle flag", {{(W-1){1'b0}}, bus_idle}, {{(W-1){1'b0}}, 1'b1});

        // Fixed extreme data sets, then pseudo-random ones
        for (int k = 0; k < 6; k++) begin
            logic [N*W-1:0] d;
            if (k == 0)      d = '0;
            else if (k == 1) d = '1;
            else             d = next_data();
            for (int p = 0; p < (1 << N); p++) begin
                apply_and_judge(p[N-1:0], d);
            end
        end

        // R7: end sources alone, with a clash between them
        apply_and_judge(4'b0001, {8'h11, 8'h22, 8'h33, 8'hA5});
        check("R7 lowest source", bus_word, 8'hA5);
        apply_and_judge(4'b1001, {8'h11, 8'h22, 8'h33, 8'hA5});
        apply_and_judge(4'b1000, {8'h5A, 8'h22, 8'h33, 8'hA5});
        check("R7 highest source", bus_word, 8'h5A);

        // R9: no memory; same pattern after a clash and after idle gives same word
        apply_and_judge(4'b0110, {8'h00, 8'hC3, 8'h3C, 8'h00});
        apply_and_judge(4'b0100, {8'h00, 8'hC3, 8'h3C, 8'h00});
        check("R9 after clash", bus_word, 8'hC3);
        apply_and_judge(4'b0000, {8'h00, 8'hC3, 8'h3C, 8'h00});
        apply_and_judge(4'b0100, {8'h00, 8'hC3, 8'h3C, 8'h00});
        check("R9 after idle", bus_word, 8'hC3);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule